// File: doc/BRIEF.md
# Multimode Switching Frequency Selector

This block chooses, once per switching cycle, how a boost power-factor-correction stage is driven. It has five ordered operating states: a non-switching constant peak current state used near the line zero crossings, three discontinuous-conduction states at 125 kHz, 250 kHz and 500 kHz, and a 1 MHz continuous-conduction state. As the rectified input voltage rises across a line half-cycle, the commanded peak current grows. The selector climbs through the states as that command crosses thresholds held in a small table. It falls back in the reverse order when the command shrinks. If the command passes the point where discontinuous conduction can no longer be kept, it jumps straight to continuous conduction.

The block produces the set pulse for the power-switch latch. In the discontinuous states the pulse comes from dividing the 50 MHz system clock by 400, 200 or 100. In continuous conduction it passes through the set signal of an external off-time generator. In the constant peak current state it issues no pulse at all. The block also clamps the peak-current command to the range the current DAC and the inductor allow, with tighter ceilings in the two slowest states. Two threshold banks are loaded through a simple write port, one for each output-voltage range.

Top module: `pfc_freq_mode_sel`

## Requirements
- R1: After reset the mode code is 0 (constant peak current), `ccm` is 0 and `set_pulse` is 0.
- R2: At a cycle boundary where `vin_code` is below 200 (range_hi=0) or below 400 (range_hi=1), the mode becomes 0. While the mode is 0, `set_pulse` stays 0.
- R3: In mode 0 every clock is a boundary. When `vin_code` is at or above the range's level, the mode becomes 1 (125 kHz) at the next clock edge.
- R4: In modes 1, 2 and 3, a command strictly above that state's step-up threshold (table address 0, 1 or 2 respectively) moves the mode up by one at the boundary. From mode 3 the move goes to 4 (1 MHz CCM, `ccm`=1). A command equal to the threshold does not move it.
- R5: In modes 2, 3 and 4, a command at or below the step-up threshold of the state one lower (addresses 0, 1, 2) moves the mode down by one at the boundary.
- R6: In modes 1, 2 and 3, a command strictly above that state's boundary limit (table address 3, 4 or 5) moves the mode straight to 4 at the boundary.
- R7: In modes 1, 2 and 3, `set_pulse` is a one-clock pulse repeating every 400, 200 and 100 clocks respectively.
- R8: In mode 4, `set_pulse` equals `otg_set`, and the mode is re-evaluated only on clocks where `otg_set` is 1.
- R9: In modes 1 to 3 the mode changes only on the clock carrying a `set_pulse`. The first period in the new mode is a full period of the new divisor.
- R10: `ipk_dac` equals `ipk_cmd` limited to the range 137..4095. In mode 1 the ceiling is 1365 and in mode 2 it is 1638.
- R11: The table write port stores `tbl_data` at (`tbl_bank`, `tbl_addr`) when `tbl_we` is 1. Bank 0 serves range_hi=0 and bank 1 serves range_hi=1, and the bank in use follows `range_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vin_code | input | 12 | Instantaneous rectified input voltage, 0.1 V per LSB |
| range_hi | input | 1 | Output-voltage range select, 0 low range, 1 high range |
| ipk_cmd | input | 12 | Computed peak-current command, full scale 3 A |
| otg_set | input | 1 | Set signal from the off-time generator |
| tbl_we | input | 1 | Threshold table write enable |
| tbl_bank | input | 1 | Bank to write |
| tbl_addr | input | 3 | Entry to write: 0-2 step-up thresholds, 3-5 boundary limits |
| tbl_data | input | 12 | Threshold value to write |
| mode | output | 3 | Current state: 0 constant peak, 1 125 kHz, 2 250 kHz, 3 500 kHz, 4 CCM |
| ccm | output | 1 | High in continuous-conduction mode |
| set_pulse | output | 1 | Latch set pulse |
| ipk_dac | output | 12 | Clamped peak-current code for the DAC |

## Verification
A wrong internal state shows at the ports within one switching period. A mode register stuck or stepped wrongly gives `set_pulse` spacing that differs from 400, 200 or 100 clocks at the very next pulse. In the same clock it also changes the `ipk_dac` ceiling, since the clamp follows the mode without delay. A divider counter that starts a new mode mid-count shows as a short first period. A table bank read from the wrong range shows as a jump or a step at a boundary that the other bank would not cause. A mode change outside a boundary is seen directly, because the mode code is sampled every clock.

// File: rtl/pfc_fsel_pkg.sv
package pfc_fsel_pkg;

  parameter int unsigned CODE_W = 12;
  parameter int unsigned N_FREQ = 3;

  typedef enum logic [2:0] {
    MODE_CPC = 3'd0,
    MODE_F1  = 3'd1,
    MODE_F2  = 3'd2,
    MODE_F3  = 3'd3,
    MODE_CCM = 3'd4
  } fmode_e;

  typedef logic [N_FREQ-1:0][CODE_W-1:0] thr_vec_t;

  // Limit a command to [lo, hi].
  function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] cmd,
                                                   input logic [CODE_W-1:0] lo,
                                                   input logic [CODE_W-1:0] hi);
    if (cmd < lo)      return lo;
    else if (cmd > hi) return hi;
    else               return cmd;
  endfunction

  // State chosen at a switching-cycle boundary.
  function automatic fmode_e next_mode(input fmode_e cur,
                                       input logic below_zc,
                                       input logic [CODE_W-1:0] ipk,
                                       input thr_vec_t up,
                                       input thr_vec_t bnd);
    fmode_e nm;
    nm = cur;
    if (below_zc) begin
      nm = MODE_CPC;
    end else begin
      unique case (cur)
        MODE_CPC: nm = MODE_F1;
        MODE_F1: begin
          if (ipk > bnd[0])     nm = MODE_CCM;
          else if (ipk > up[0]) nm = MODE_F2;
        end
        MODE_F2: begin
          if (ipk > bnd[1])       nm = MODE_CCM;
          else if (ipk > up[1])   nm = MODE_F3;
          else if (ipk <= up[0])  nm = MODE_F1;
        end
        MODE_F3: begin
          if (ipk > bnd[2])       nm = MODE_CCM;
          else if (ipk > up[2])   nm = MODE_CCM;
          else if (ipk <= up[1])  nm = MODE_F2;
        end
        MODE_CCM: begin
          if (ipk <= up[2])       nm = MODE_F3;
        end
        default: nm = MODE_CPC;
      endcase
    end
    return nm;
  endfunction

endpackage

// File: rtl/pfc_fsel_thr_tbl.sv
module pfc_fsel_thr_tbl
  import pfc_fsel_pkg::*;
#(
  parameter int unsigned ENTRIES = 2 * N_FREQ,
  parameter int unsigned AW      = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              wr_bank,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              rd_bank,
  output thr_vec_t          up_o,
  output thr_vec_t          bnd_o
);

  logic [CODE_W-1:0] mem [0:1][0:ENTRIES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int e = 0; e < int'(ENTRIES); e++)
          mem[b][e] <= '1;
    end else if (we && (int'(wr_addr) < int'(ENTRIES))) begin
      mem[wr_bank][wr_addr] <= wr_data;
    end
  end

  for (genvar i = 0; i < int'(N_FREQ); i++) begin : g_rd
    assign up_o[i]  = mem[rd_bank][i];
    assign bnd_o[i] = mem[rd_bank][i + int'(N_FREQ)];
  end

  // R11: writes land only in the populated entries
  assert_wr_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(wr_addr) < int'(ENTRIES)));

endmodule

// File: rtl/pfc_fsel_div.sv
module pfc_fsel_div #(
  parameter int unsigned DIV_A = 400,
  parameter int unsigned DIV_B = 200,
  parameter int unsigned DIV_C = 100,
  localparam int unsigned DMAX_AB = (DIV_A > DIV_B) ? DIV_A : DIV_B,
  localparam int unsigned DMAX    = (DMAX_AB > DIV_C) ? DMAX_AB : DIV_C,
  localparam int unsigned CW      = $clog2(DMAX)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    unique case (sel)
      2'd0:    last = CW'(DIV_A - 1);
      2'd1:    last = CW'(DIV_B - 1);
      default: last = CW'(DIV_C - 1);
    endcase
  end

  assign tick = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (tick)       cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // R7: the set pulse is one clock wide
  assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R9: a period never overruns the selected divisor
  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= last));

endmodule

// File: rtl/pfc_fsel_fsm.sv
module pfc_fsel_fsm
  import pfc_fsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              below_zc,
  input  logic [CODE_W-1:0] ipk,
  input  thr_vec_t          up,
  input  thr_vec_t          bnd,
  output fmode_e            mode_q
);

  fmode_e mode_d;

  always_comb mode_d = next_mode(mode_q, below_zc, ipk, up, bnd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= MODE_CPC;
    else if (step) mode_q <= mode_d;
  end

  // R9: no mode change away from a cycle boundary
  assert_hold_off_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> (mode_q == $past(mode_q)));

  // R4: ordinary moves are single steps; only CPC and CCM are reached by jumps
  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (mode_q == MODE_CCM || mode_q == MODE_CPC ||
              3'(mode_q) == 3'($past(mode_q)) ||
              3'(mode_q) == 3'($past(mode_q)) + 3'd1 ||
              3'(mode_q) + 3'd1 == 3'($past(mode_q))));

endmodule

// File: rtl/pfc_freq_mode_sel.sv
module pfc_freq_mode_sel
  import pfc_fsel_pkg::*;
#(
  parameter int unsigned VIN_W      = 12,
  parameter int unsigned DIV_F1     = 400,
  parameter int unsigned DIV_F2     = 200,
  parameter int unsigned DIV_F3     = 100,
  parameter int unsigned VZC_LO     = 200,
  parameter int unsigned VZC_HI     = 400,
  parameter int unsigned IPK_MIN    = 137,
  parameter int unsigned IPK_MAX    = 4095,
  parameter int unsigned IPK_LIM_F1 = 1365,
  parameter int unsigned IPK_LIM_F2 = 1638,
  localparam int unsigned TBL_AW    = $clog2(2 * N_FREQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VIN_W-1:0]  vin_code,
  input  logic              range_hi,
  input  logic [CODE_W-1:0] ipk_cmd,
  input  logic              otg_set,
  input  logic              tbl_we,
  input  logic              tbl_bank,
  input  logic [TBL_AW-1:0] tbl_addr,
  input  logic [CODE_W-1:0] tbl_data,
  output logic [2:0]        mode,
  output logic              ccm,
  output logic              set_pulse,
  output logic [CODE_W-1:0] ipk_dac
);

  fmode_e      cur_mode;
  thr_vec_t    up_thr;
  thr_vec_t    bnd_thr;
  logic        below_zc;
  logic        dcm_run;
  logic [1:0]  div_sel;
  logic        div_tick;
  logic        cyc_end;
  logic [CODE_W-1:0] ceil_code;

  pfc_fsel_thr_tbl u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (tbl_we),
    .wr_bank (tbl_bank),
    .wr_addr (tbl_addr),
    .wr_data (tbl_data),
    .rd_bank (range_hi),
    .up_o    (up_thr),
    .bnd_o   (bnd_thr)
  );

  assign below_zc = range_hi ? (vin_code < VIN_W'(VZC_HI))
                             : (vin_code < VIN_W'(VZC_LO));

  always_comb begin
    dcm_run = 1'b1;
    div_sel = 2'd0;
    unique case (cur_mode)
      MODE_F1: div_sel = 2'd0;
      MODE_F2: div_sel = 2'd1;
      MODE_F3: div_sel = 2'd2;
      default: dcm_run = 1'b0;
    endcase
  end

  pfc_fsel_div #(
    .DIV_A (DIV_F1),
    .DIV_B (DIV_F2),
    .DIV_C (DIV_F3)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (dcm_run),
    .sel   (div_sel),
    .tick  (div_tick)
  );

  // Switching-cycle boundary: every clock in CPC, the divider wrap in DCM,
  // the off-time generator set in CCM.
  always_comb begin
    unique case (cur_mode)
      MODE_CPC: cyc_end = 1'b1;
      MODE_CCM: cyc_end = otg_set;
      default:  cyc_end = div_tick;
    endcase
  end

  pfc_fsel_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (cyc_end),
    .below_zc (below_zc),
    .ipk      (ipk_cmd),
    .up       (up_thr),
    .bnd      (bnd_thr),
    .mode_q   (cur_mode)
  );

  always_comb begin
    unique case (cur_mode)
      MODE_F1: ceil_code = CODE_W'(IPK_LIM_F1);
      MODE_F2: ceil_code = CODE_W'(IPK_LIM_F2);
      default: ceil_code = CODE_W'(IPK_MAX);
    endcase
  end

  assign mode      = cur_mode;
  assign ccm       = (cur_mode == MODE_CCM);
  assign set_pulse = ccm ? otg_set : div_tick;
  assign ipk_dac   = clamp_code(ipk_cmd, CODE_W'(IPK_MIN), ceil_code);

  // R2: no set pulse while not switching
  assert_no_set_in_cpc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |-> !set_pulse);

  // R8: without an off-time set, CCM is held
  assert_ccm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ccm && !otg_set) |=> ccm);

  // R10: DAC code always inside the global window
  assert_dac_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ipk_dac >= CODE_W'(IPK_MIN)) && (ipk_dac <= CODE_W'(IPK_MAX)));

  // R10: tighter ceilings in the two slowest states
  assert_dac_slow_ceiling_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd1) |-> (ipk_dac <= CODE_W'(IPK_LIM_F1))) and
    ((mode == 3'd2) |-> (ipk_dac <= CODE_W'(IPK_LIM_F2))));

endmodule

// File: tb/pfc_freq_mode_sel_bench.sv
module pfc_freq_mode_sel_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] vin_code = '0;
  logic        range_hi = 1'b0;
  logic [11:0] ipk_cmd = '0;
  logic        otg_set = 1'b0;
  logic        tbl_we = 1'b0;
  logic        tbl_bank = 1'b0;
  logic [2:0]  tbl_addr = '0;
  logic [11:0] tbl_data = '0;
  logic [2:0]  mode;
  logic        ccm;
  logic        set_pulse;
  logic [11:0] ipk_dac;

  int n_chk  = 0;
  int n_fail = 0;

  typedef struct {
    string req;
    int    mode;
    int    dac;
  } exp_t;
  exp_t sb_q[$];

  pfc_freq_mode_sel u_pfc_freq_mode_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .vin_code  (vin_code),
    .range_hi  (range_hi),
    .ipk_cmd   (ipk_cmd),
    .otg_set   (otg_set),
    .tbl_we    (tbl_we),
    .tbl_bank  (tbl_bank),
    .tbl_addr  (tbl_addr),
    .tbl_data  (tbl_data),
    .mode      (mode),
    .ccm       (ccm),
    .set_pulse (set_pulse),
    .ipk_dac   (ipk_dac)
  );

  always #2.5ns clk = ~clk;

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Reference clamp written from R10
  function automatic int ref_dac(input int m, input int cmd);
    int hi;
    hi = (m == 1) ? 1365 : (m == 2) ? 1638 : 4095;
    if (cmd < 137) return 137;
    if (cmd > hi)  return hi;
    return cmd;
  endfunction

  // Monitor: pops expectations and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.req, " mode"}, int'(mode), e.mode);
        chk({e.req, " ccm"},  int'(ccm),  (e.mode == 4) ? 1 : 0);
        chk({e.req, " dac"},  int'(ipk_dac), e.dac);
      end
    end
  end

  // Driver side: queue an expectation for the next falling edge
  task automatic expect_state(input string req, input int m);
    exp_t e;
    e.req = req; e.mode = m; e.dac = ref_dac(m, int'(ipk_cmd));
    sb_q.push_back(e);
    @(negedge clk); #1ns;
  endtask

  task automatic drive(input int vin, input int ipk, input bit rng);
    @(posedge clk); #1ns;
    vin_code = 12'(vin); ipk_cmd = 12'(ipk); range_hi = rng;
  endtask

  task automatic wr(input bit bank, input int addr, input int data);
    @(posedge clk); #1ns;
    tbl_we = 1'b1; tbl_bank = bank; tbl_addr = 3'(addr); tbl_data = 12'(data);
    @(posedge clk); #1ns;
    tbl_we = 1'b0;
  endtask

  task automatic wait_pulse(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!set_pulse && cnt < 2000);
  endtask

  task automatic dcm_boundary(input string req, input int old_m, input int new_m);
    int c;
    wait_pulse(c);
    chk({req, " unchanged up to pulse"}, int'(mode), old_m);
    @(posedge clk); #1ns;
    expect_state(req, new_m);
  endtask

  task automatic otg_boundary(input string req, input int new_m);
    @(posedge clk); #1ns;
    otg_set = 1'b1;
    @(negedge clk);
    chk({req, " set follows off-time (R8)"}, int'(set_pulse), 1);
    @(posedge clk); #1ns;
    otg_set = 1'b0;
    expect_state(req, new_m);
  endtask

  task automatic check_period(input string req, input int expv);
    int a, c;
    wait_pulse(a);
    wait_pulse(c);
    chk(req, c, expv);
  endtask

  task automatic count_pulses(input int n, output int k);
    k = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (set_pulse) k++;
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #750us;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual expired expected completion");
    finish_run();
  end

  initial begin
    int k;
    repeat (5) @(posedge clk);
    #1ns rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset ccm", int'(ccm), 0);
    chk("R1 reset set_pulse", int'(set_pulse), 0);
    chk("R10 floor at zero command", int'(ipk_dac), 137);

    // R11: load both banks
    wr(0, 0, 1000); wr(0, 1, 2000); wr(0, 2, 3000);
    wr(0, 3, 3500); wr(0, 4, 3600); wr(0, 5, 3700);
    wr(1, 0, 500);  wr(1, 1, 600);  wr(1, 2, 700);
    wr(1, 3, 800);  wr(1, 4, 900);  wr(1, 5, 1000);

    // R2: below the low-range level, no switching
    drive(100, 500, 0);
    count_pulses(600, k);
    chk("R2 no pulses below level", k, 0);
    chk("R2 mode stays 0", int'(mode), 0);

    // R3: leave CPC at the next clock
    drive(250, 500, 0);
    @(posedge clk); #1ns;
    expect_state("R3 enter 125k", 1);
    check_period("R7 period 125k", 400);

    // R10 ceiling in mode 1, then R4 step to 250k
    drive(250, 1500, 0);
    expect_state("R10 ceiling 125k", 1);
    dcm_boundary("R4 step to 250k", 1, 2);
    check_period("R9 R7 period 250k", 200);

    drive(250, 2500, 0);
    dcm_boundary("R4 step to 500k", 2, 3);
    check_period("R9 R7 period 500k", 100);

    drive(250, 3000, 0);
    dcm_boundary("R4 equal threshold holds", 3, 3);

    drive(250, 3200, 0);
    dcm_boundary("R4 step to CCM", 3, 4);

    // R8: CCM held without off-time set, pulse passes through
    drive(250, 2900, 0);
    count_pulses(300, k);
    chk("R8 no set without off-time", k, 0);
    chk("R8 CCM held", int'(mode), 4);
    otg_boundary("R5 down to 500k", 3);

    drive(250, 1800, 0);
    dcm_boundary("R5 down to 250k with R10 ceiling", 3, 2);
    drive(250, 800, 0);
    dcm_boundary("R5 down to 125k", 2, 1);

    drive(150, 800, 0);
    dcm_boundary("R2 back to CPC", 1, 0);
    count_pulses(500, k);
    chk("R2 silent in CPC", k, 0);

    // R6: jump from 125k to CCM
    drive(250, 3550, 0);
    @(posedge clk); #1ns;
    expect_state("R3 re-enter 125k", 1);
    dcm_boundary("R6 jump to CCM", 1, 4);

    // R11: high range uses bank 1 and the 400 level
    drive(300, 850, 1);
    otg_boundary("R11 R2 high-range level", 0);
    drive(450, 850, 1);
    @(posedge clk); #1ns;
    expect_state("R11 R3 enter 125k high range", 1);
    dcm_boundary("R11 R6 bank 1 boundary", 1, 4);

    drive(450, 4095, 1);
    expect_state("R10 full-scale in CCM", 4);
    @(negedge clk);
    chk("R8 set low with off-time low", int'(set_pulse), 0);

    finish_run();
  end

endmodule